// File: doc/BRIEF.md
# Learn/Test Phase Sequencer for a Layered Training Datapath

This block paces a small layered learning datapath from one base clock, normally the video pixel clock (about 24.5 MHz). It never creates derived clocks. Instead, each base-clock cycle it raises at most one of four single-cycle enables: hidden-layer forward, output-layer forward, output-layer backward and hidden-layer backward.

In learn mode one training epoch takes four cycles, with the four enables in that order. Epochs follow each other with no gap. An epoch counter stops the run when it reaches a maximum that is captured when the run starts. There is no error-based stop. In test mode one pixel takes two cycles: hidden forward, then output forward. The backward enables stay low in test mode.

A start pulse or a frame-start pulse rearms learning, for example to retrain in the next video frame after a scene change. Mode changes and restarts take effect only where an epoch or a pixel pass ends, so a sequence is never cut short.

Top module: `nn_phase_seq`

## Requirements
- R1: After reset all four enables, `done_o` and `busy_o` are low, and they stay low while no start arrives and learn mode (`mode_i`=0) is selected.
- R2: In learn mode a learning epoch drives hidden-forward, output-forward, output-backward and hidden-backward on four consecutive cycles, each for exactly one cycle. When the sequencer is idle, the first hidden-forward appears the cycle after the start pulse is sampled.
- R3: Epochs of one learning run follow back to back with a period of four cycles, and `busy_o` is high while the run is underway.
- R4: With a maximum of N>0, captured from `max_epochs_i` when the restart is applied, exactly N epochs run. In the cycle after the last hidden-backward enable, all enables are low, `done_o` is high and `busy_o` is low.
- R5: `done_o` stays high, with no enables in learn mode, until a start or frame-start pulse. Either pulse begins a fresh run counted from zero.
- R6: In test mode (`mode_i`=1) hidden-forward and output-forward alternate every cycle, starting with hidden-forward. Both backward enables stay low.
- R7: A change of `mode_i` is acted on only at an epoch or pixel boundary. A learning epoch that is under way finishes all four steps, and a test pass finishes both steps.
- R8: A start or frame-start pulse that arrives in the middle of an epoch is held until that epoch ends. At that point the epoch count restarts from zero, and that partial epoch is not counted.
- R9: A restart with a maximum of zero ends the run at once: no learning epoch is issued, `done_o` goes high and `busy_o` stays low.
- R10: Test passes inserted during a learning run do not count as epochs. When learn mode returns, the run resumes with its remaining epochs.
- R11: At most one of the four enables is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base (pixel) clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = learn, 1 = test; sampled at boundaries |
| start_i | input | 1 | Pulse: begin a learning run |
| frame_start_i | input | 1 | Pulse: restart learning at a new frame |
| max_epochs_i | input | EPOCH_W (20) | Epoch limit, captured when a restart is applied |
| hid_fwd_en_o | output | 1 | Hidden-layer forward enable |
| out_fwd_en_o | output | 1 | Output-layer forward enable |
| out_bwd_en_o | output | 1 | Output-layer backward enable |
| hid_bwd_en_o | output | 1 | Hidden-layer backward enable |
| done_o | output | 1 | Learning run finished; held until restart |
| busy_o | output | 1 | Learning run in progress |

## Verification
The bench compares the enable vector slot by slot against the expected sequence for several stimulus patterns:
- A plain learning run with a small limit confirms the order, the four-cycle spacing and the exact stopping point.
- A frame-start rearm after completion shows that either pulse restarts the run and that `done_o` is held until then.
- A zero limit covers the immediate-stop corner.
- Free-running test mode shows the two-cycle pass with no backward enables.
- Switching to test mode in the middle of an epoch and back again separates boundary-only mode changes, and shows whether test passes are wrongly counted as epochs.
- A frame-start pulse in the middle of an epoch reveals whether the restart is deferred and whether the partial epoch is counted: the run ends two full epochs after the boundary instead of one.

// File: rtl/nn_phase_pkg.sv
package nn_phase_pkg;

    localparam int DEF_EPOCH_W = 20;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HF   = 3'd1,
        PH_OF   = 3'd2,
        PH_OB   = 3'd3,
        PH_HB   = 3'd4
    } phase_t;

    typedef struct packed {
        logic hid_fwd;
        logic out_fwd;
        logic out_bwd;
        logic hid_bwd;
    } strobe_t;

    function automatic strobe_t phase_strobes(phase_t ph);
        strobe_t s;
        s = '0;
        case (ph)
            PH_HF:   s.hid_fwd = 1'b1;
            PH_OF:   s.out_fwd = 1'b1;
            PH_OB:   s.out_bwd = 1'b1;
            PH_HB:   s.hid_bwd = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nn_phase_fsm.sv
module nn_phase_fsm
    import nn_phase_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    mode_i,
    input  logic    learn_go_i,
    output strobe_t strobe_o,
    output logic    bound_o,
    output logic    ep_end_o
);

    phase_t ph_q, ph_d;
    logic   test_q, test_d;

    always_comb begin
        bound_o  = (ph_q == PH_IDLE) || (ph_q == PH_HB) ||
                   ((ph_q == PH_OF) && test_q);
        ep_end_o = (ph_q == PH_HB);
        strobe_o = phase_strobes(ph_q);
    end

    always_comb begin
        ph_d   = ph_q;
        test_d = test_q;
        if (bound_o) begin
            if (mode_i) begin
                ph_d   = PH_HF;
                test_d = 1'b1;
            end else if (learn_go_i) begin
                ph_d   = PH_HF;
                test_d = 1'b0;
            end else begin
                ph_d   = PH_IDLE;
                test_d = 1'b0;
            end
        end else begin
            case (ph_q)
                PH_HF:   ph_d = PH_OF;
                PH_OF:   ph_d = PH_OB;
                PH_OB:   ph_d = PH_HB;
                default: ph_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            test_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            test_q <= test_d;
        end
    end

    // R11: never two enables together
    a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));
    // R2: hidden forward is followed by output forward
    a_r2_hf_then_of: assert property (@(posedge clk) disable iff (rst)
        strobe_o.hid_fwd |=> strobe_o.out_fwd);
    // R2: learning output forward is followed by output backward
    a_r2_of_then_ob: assert property (@(posedge clk) disable iff (rst)
        (strobe_o.out_fwd && !test_q) |=> strobe_o.out_bwd);
    // R2: output backward is followed by hidden backward
    a_r2_ob_then_hb: assert property (@(posedge clk) disable iff (rst)
        strobe_o.out_bwd |=> strobe_o.hid_bwd);
    // R6: a test pass never leads into a backward step
    a_r6_test_no_back: assert property (@(posedge clk) disable iff (rst)
        (strobe_o.out_fwd && test_q) |=> !(strobe_o.out_bwd || strobe_o.hid_bwd));

endmodule

// File: rtl/nn_epoch_ctr.sv
module nn_epoch_ctr #(
    parameter int EPOCH_W = nn_phase_pkg::DEF_EPOCH_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               frame_start_i,
    input  logic [EPOCH_W-1:0] max_i,
    input  logic               bound_i,
    input  logic               ep_end_i,
    output logic               learn_go_o,
    output logic               done_o,
    output logic               busy_o
);

    localparam int CMP_W = EPOCH_W + 1;

    logic [EPOCH_W-1:0] cnt_q;
    logic [EPOCH_W-1:0] max_q;
    logic               run_q;
    logic               done_q;
    logic               pend_q;
    logic               pend_eff;
    logic               last_ep;
    logic [CMP_W-1:0]   cnt_inc;

    always_comb begin
        pend_eff   = pend_q | start_i | frame_start_i;
        cnt_inc    = {1'b0, cnt_q} + CMP_W'(1);
        last_ep    = ep_end_i && (cnt_inc >= {1'b0, max_q});
        learn_go_o = pend_eff ? (max_i != '0) : (run_q && !last_ep);
        done_o     = done_q;
        busy_o     = run_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            max_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (bound_i && pend_eff) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            max_q  <= max_i;
            run_q  <= (max_i != '0);
            done_q <= (max_i == '0);
        end else begin
            if (pend_eff)
                pend_q <= 1'b1;
            if (ep_end_i && run_q) begin
                cnt_q <= cnt_inc[EPOCH_W-1:0];
                if (last_ep) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // R4: a running count never reaches the limit
    a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < max_q));
    // R4: done and busy are exclusive
    a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !run_q);
    // R5: done holds without a restart request
    a_r5_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done_q && !pend_eff) |=> done_q);
    // R8: a request off the boundary is kept pending
    a_r8_pend_kept: assert property (@(posedge clk) disable iff (rst)
        (pend_eff && !bound_i) |=> pend_q);

endmodule

// File: rtl/nn_phase_seq.sv
module nn_phase_seq #(
    parameter int EPOCH_W = nn_phase_pkg::DEF_EPOCH_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_i,
    input  logic               start_i,
    input  logic               frame_start_i,
    input  logic [EPOCH_W-1:0] max_epochs_i,
    output logic               hid_fwd_en_o,
    output logic               out_fwd_en_o,
    output logic               out_bwd_en_o,
    output logic               hid_bwd_en_o,
    output logic               done_o,
    output logic               busy_o
);
    import nn_phase_pkg::*;

    strobe_t strobe;
    logic    bound;
    logic    ep_end;
    logic    learn_go;

    nn_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_i),
        .learn_go_i (learn_go),
        .strobe_o   (strobe),
        .bound_o    (bound),
        .ep_end_o   (ep_end)
    );

    nn_epoch_ctr #(.EPOCH_W(EPOCH_W)) u_ctr (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .frame_start_i (frame_start_i),
        .max_i         (max_epochs_i),
        .bound_i       (bound),
        .ep_end_i      (ep_end),
        .learn_go_o    (learn_go),
        .done_o        (done_o),
        .busy_o        (busy_o)
    );

    assign hid_fwd_en_o = strobe.hid_fwd;
    assign out_fwd_en_o = strobe.out_fwd;
    assign out_bwd_en_o = strobe.out_bwd;
    assign hid_bwd_en_o = strobe.hid_bwd;

    // R4: after completion no backward step appears
    a_r4_done_no_back: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !(out_bwd_en_o || hid_bwd_en_o));

endmodule

// File: tb/nn_phase_seq_tb.sv
module nn_phase_seq_tb;

    localparam int EW = 20;
    localparam logic [3:0] V_HF = 4'b1000;
    localparam logic [3:0] V_OF = 4'b0100;
    localparam logic [3:0] V_OB = 4'b0010;
    localparam logic [3:0] V_HB = 4'b0001;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_i = 1'b0;
    logic          start_i = 1'b0;
    logic          frame_start_i = 1'b0;
    logic [EW-1:0] max_epochs_i = '0;
    logic          hf, of, ob, hb, done, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nn_phase_seq #(.EPOCH_W(EW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .mode_i        (mode_i),
        .start_i       (start_i),
        .frame_start_i (frame_start_i),
        .max_epochs_i  (max_epochs_i),
        .hid_fwd_en_o  (hf),
        .out_fwd_en_o  (of),
        .out_bwd_en_o  (ob),
        .hid_bwd_en_o  (hb),
        .done_o        (done),
        .busy_o        (busy)
    );

    function automatic logic [3:0] vec();
        return {hf, of, ob, hb};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_vec(input string req, input logic [3:0] exp);
        check(vec() == exp, req, "enables", 32'(vec()), 32'(exp));
    endtask

    task automatic expect_flags(input string req, input logic d, input logic b);
        check(done == d, req, "done", 32'(done), 32'(d));
        check(busy == b, req, "busy", 32'(busy), 32'(b));
    endtask

    // check n complete learning epochs, starting with the current slot
    task automatic learn_epochs(input int n, input string req);
        logic [3:0] pat [4];
        pat[0] = V_HF; pat[1] = V_OF; pat[2] = V_OB; pat[3] = V_HB;
        for (int e = 0; e < n; e++) begin
            for (int s = 0; s < 4; s++) begin
                expect_vec(req, pat[s]);
                check(busy == 1'b1, req, "busy during run", 32'(busy), 32'd1);
                tick();
            end
        end
    endtask

    task automatic pulse_start(input logic [EW-1:0] mx);
        max_epochs_i = mx;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    task automatic pulse_frame(input logic [EW-1:0] mx);
        max_epochs_i = mx;
        frame_start_i = 1'b1;
        tick();
        frame_start_i = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            expect_vec("R1", 4'b0000);
            expect_flags("R1", 1'b0, 1'b0);
            tick();
        end
    endtask

    task automatic t_learn_run();
        pulse_start(EW'(3));
        learn_epochs(3, "R2_R3");
        expect_vec("R4", 4'b0000);
        expect_flags("R4", 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            tick();
            expect_vec("R5", 4'b0000);
            check(done == 1'b1, "R5", "done held", 32'(done), 32'd1);
        end
    endtask

    task automatic t_frame_rearm();
        pulse_frame(EW'(2));
        check(done == 1'b0, "R5", "done cleared", 32'(done), 32'd0);
        learn_epochs(2, "R5");
        expect_vec("R5", 4'b0000);
        expect_flags("R5", 1'b1, 1'b0);
        tick();
    endtask

    task automatic t_max_zero();
        pulse_start(EW'(0));
        expect_vec("R9", 4'b0000);
        expect_flags("R9", 1'b1, 1'b0);
        tick();
        expect_vec("R9", 4'b0000);
        tick();
    endtask

    task automatic t_test_mode();
        mode_i = 1'b1;
        tick();
        for (int i = 0; i < 10; i++) begin
            expect_vec("R6", (i % 2 == 0) ? V_HF : V_OF);
            tick();
        end
        // now showing hidden forward; leave test mode mid pass
        expect_vec("R6", V_HF);
        mode_i = 1'b0;
        tick();
        expect_vec("R7", V_OF);
        tick();
        expect_vec("R7", 4'b0000);
        tick();
    endtask

    task automatic t_mode_mid_epoch();
        pulse_start(EW'(4));
        expect_vec("R2", V_HF);
        tick();
        expect_vec("R2", V_OF);
        tick();
        expect_vec("R2", V_OB);
        mode_i = 1'b1;
        tick();
        expect_vec("R7", V_HB);
        tick();
        expect_vec("R7", V_HF);
        tick();
        expect_vec("R7", V_OF);
        tick();
        expect_vec("R10", V_HF);
        check(busy == 1'b1, "R10", "run paused", 32'(busy), 32'd1);
        mode_i = 1'b0;
        tick();
        expect_vec("R7", V_OF);
        tick();
        learn_epochs(3, "R10");
        expect_vec("R10", 4'b0000);
        expect_flags("R10", 1'b1, 1'b0);
        tick();
    endtask

    task automatic t_restart_mid_epoch();
        pulse_start(EW'(2));
        expect_vec("R8", V_HF);
        tick();
        expect_vec("R8", V_OF);
        frame_start_i = 1'b1;
        tick();
        frame_start_i = 1'b0;
        expect_vec("R8", V_OB);
        tick();
        expect_vec("R8", V_HB);
        tick();
        learn_epochs(2, "R8");
        expect_vec("R8", 4'b0000);
        expect_flags("R8", 1'b1, 1'b0);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_learn_run();
        t_frame_rearm();
        t_max_zero();
        t_test_mode();
        t_mode_mid_epoch();
        t_restart_mid_epoch();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule